// File: doc/BRIEF.md
# Byte-Lane True Dual-Port RAM

This block is a synchronous memory with two ports, A and B, that share one storage array and nothing else. Each port has its own enable, per-lane write enables, address, write data and read data. On every rising clock edge each port performs at most one operation, either a read or a write. Every input is sampled on that edge, so nothing in the array or on the read outputs moves between edges.

The data word is split into byte lanes of nine bits: eight data bits plus one parity bit, which is written and stored like any other bit. Each lane has its own write enable. Each port is given, at build time, its own rule for what its read output shows during a write: the word stored before the write, the word as it stands after the write, or no change at all. Also at build time, either port can get an extra output register that adds one cycle of read latency to allow a higher clock rate. Both ports run on one common clock. That keeps the shared array in a single clocked process and makes same-edge behaviour between the ports exact.

Top module: `twin_port_ram`

## Requirements
- R1: The two ports share one array. Writes from both ports to different addresses on the same edge both take effect, and either port can read what the other port wrote.
- R2: An enabled operation with all write enables low loads the addressed word into the port's read register on that edge. Without the pipeline option the word appears on the read data output just after that edge.
- R3: On a port set to show-old, an enabled write puts the word stored before the write onto the read output.
- R4: On a port set to show-new, an enabled write puts the word as it stands after the write onto the read output. Lanes that are not written show their stored contents.
- R5: On a port set to keep-output, an enabled write leaves the read output unchanged.
- R6: The word is LANES lanes of 9 bits. Write enable bit i controls data bits [9i+8:9i], and bit 9i+8 is that lane's parity bit. A lane whose write enable is low keeps its stored contents.
- R7: While a port's enable is low, that port changes nothing in the array and its read register holds, whatever its write enables, address and data are.
- R8: A read on one port of an address that the other port writes on the same edge returns the word stored before that write.
- R9: With the pipeline option, the read data reaches the output one edge later than it would without it. The output shows the previous read register contents right after the operation's edge.
- R10: Reset (rst_n low at an edge) clears the read registers and output registers to zero. It does not clear the array.
- R11: Both ports writing the same address on the same edge is forbidden and leaves the stored word undefined. It is flagged as a usage error.
- R12: The read data holds its value across any number of cycles until the next enabled operation on that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read registers |
| a_en | input | 1 | Port A operation enable |
| a_we | input | LANES | Port A per-lane write enables |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANES*9 | Port A write data, nine bits per lane |
| a_rdata | output | LANES*9 | Port A read data |
| b_en | input | 1 | Port B operation enable |
| b_we | input | LANES | Port B per-lane write enables |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANES*9 | Port B write data, nine bits per lane |
| b_rdata | output | LANES*9 | Port B read data |

## Verification
A wrong lane-merge or write-mode choice inside a port shows on that port's read output on the edge of the write itself. On a pipelined port it shows one edge later. A lane that is written when it should not be, or a write that leaks through a low enable, stays hidden in the array. It surfaces only on the first later read of that address, so every write scenario is followed by a read-back through a port. A read register that drifts while idle is caught by sampling the outputs over several idle cycles.

// File: rtl/twin_port_ram_pkg.sv
package twin_port_ram_pkg;

    // What a port's read output shows on a cycle in which that port writes
    typedef enum logic [1:0] {
        WR_SHOW_OLD  = 2'd0,   // word stored before the write
        WR_SHOW_NEW  = 2'd1,   // word after the write, lanes merged
        WR_KEEP_OUT  = 2'd2    // read output untouched
    } wr_view_e;

    localparam int unsigned LANE_BITS = 9;   // eight data bits plus parity

endpackage

// File: rtl/tpr_store.sv
module tpr_store #(
    parameter int unsigned LANES  = 4,
    parameter int unsigned DEPTH  = 1024,
    localparam int unsigned LW     = twin_port_ram_pkg::LANE_BITS,
    localparam int unsigned DW     = LANES * LW,
    localparam int unsigned AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             a_en,
    input  logic [LANES-1:0] a_we,
    input  logic [AW-1:0]    a_addr,
    input  logic [DW-1:0]    a_wdata,
    output logic [DW-1:0]    a_old,
    input  logic             b_en,
    input  logic [LANES-1:0] b_we,
    input  logic [AW-1:0]    b_addr,
    input  logic [DW-1:0]    b_wdata,
    output logic [DW-1:0]    b_old
);

    logic [DW-1:0] cells [DEPTH];

    // Both ports write in one clocked process; lanes with low enables are left alone
    always_ff @(posedge clk) begin
        for (int l = 0; l < int'(LANES); l++) begin
            if (a_en && a_we[l]) begin
                cells[a_addr][l*LW +: LW] <= a_wdata[l*LW +: LW];
            end
            if (b_en && b_we[l]) begin
                cells[b_addr][l*LW +: LW] <= b_wdata[l*LW +: LW];
            end
        end
    end

    // Contents before this edge's writes: feeds each port's read register
    assign a_old = cells[a_addr];
    assign b_old = cells[b_addr];

endmodule

// File: rtl/tpr_port.sv
module tpr_port #(
    parameter int unsigned                 LANES = 4,
    parameter twin_port_ram_pkg::wr_view_e MODE  = twin_port_ram_pkg::WR_SHOW_OLD,
    parameter bit                          PIPE  = 1'b0,
    localparam int unsigned                LW    = twin_port_ram_pkg::LANE_BITS,
    localparam int unsigned                DW    = LANES * LW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [LANES-1:0] we,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    old_word,
    output logic [DW-1:0]    rdata
);

    import twin_port_ram_pkg::*;

    logic [DW-1:0] merged;
    logic [DW-1:0] rd_q;
    logic          is_write;

    assign is_write = |we;

    // Word as it will stand after this edge's write on this port
    always_comb begin
        merged = old_word;
        for (int l = 0; l < int'(LANES); l++) begin
            if (we[l]) begin
                merged[l*LW +: LW] = wdata[l*LW +: LW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (en) begin
            if (!is_write) begin
                rd_q <= old_word;
            end else if (MODE == WR_SHOW_OLD) begin
                rd_q <= old_word;
            end else if (MODE == WR_SHOW_NEW) begin
                rd_q <= merged;
            end else begin
                rd_q <= rd_q;
            end
        end
    end

    generate
        if (PIPE) begin : g_pipe
            logic [DW-1:0] out_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    out_q <= '0;
                end else begin
                    out_q <= rd_q;
                end
            end
            assign rdata = out_q;
        end else begin : g_direct
            assign rdata = rd_q;
        end
    endgenerate

    // R7: disabled port leaves its read register alone
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rd_q));

    // R5: keep-output mode does not disturb the read register on a write
    p_keep_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == WR_KEEP_OUT && en && is_write) |=> $stable(rd_q));

    // R4: full-word write in show-new mode returns exactly the written data
    p_full_write_through_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == WR_SHOW_NEW && en && (&we)) |=> (rd_q == $past(wdata)));

    // R10: reset empties the read register
    p_reset_clears_r10: assert property (@(posedge clk)
        !rst_n |=> (rd_q == '0));

endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
    parameter int unsigned                 LANES  = 4,
    parameter int unsigned                 DEPTH  = 1024,
    parameter twin_port_ram_pkg::wr_view_e MODE_A = twin_port_ram_pkg::WR_SHOW_OLD,
    parameter twin_port_ram_pkg::wr_view_e MODE_B = twin_port_ram_pkg::WR_SHOW_OLD,
    parameter bit                          PIPE_A = 1'b0,
    parameter bit                          PIPE_B = 1'b0,
    localparam int unsigned                DW     = LANES * twin_port_ram_pkg::LANE_BITS,
    localparam int unsigned                ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_en,
    input  logic [LANES-1:0]  a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DW-1:0]     a_wdata,
    output logic [DW-1:0]     a_rdata,
    input  logic              b_en,
    input  logic [LANES-1:0]  b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DW-1:0]     b_wdata,
    output logic [DW-1:0]     b_rdata
);

    logic [DW-1:0] a_old;
    logic [DW-1:0] b_old;

    tpr_store #(
        .LANES (LANES),
        .DEPTH (DEPTH)
    ) store_i (
        .clk     (clk),
        .a_en    (a_en),
        .a_we    (a_we),
        .a_addr  (a_addr),
        .a_wdata (a_wdata),
        .a_old   (a_old),
        .b_en    (b_en),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .b_old   (b_old)
    );

    tpr_port #(
        .LANES (LANES),
        .MODE  (MODE_A),
        .PIPE  (PIPE_A)
    ) port_a_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (a_en),
        .we       (a_we),
        .wdata    (a_wdata),
        .old_word (a_old),
        .rdata    (a_rdata)
    );

    tpr_port #(
        .LANES (LANES),
        .MODE  (MODE_B),
        .PIPE  (PIPE_B)
    ) port_b_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (b_en),
        .we       (b_we),
        .wdata    (b_wdata),
        .old_word (b_old),
        .rdata    (b_rdata)
    );

    // R11: simultaneous writes to one address are a usage error
    p_no_shared_addr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(a_en && b_en && (|a_we) && (|b_we) && (a_addr == b_addr)));

endmodule

// File: tb/twin_port_ram_tb_top.sv
module twin_port_ram_tb_top;

    import twin_port_ram_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;
    localparam int DW = NL * 9;
    localparam int DEP = 64;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          a_en = 1'b0, b_en = 1'b0;
    logic [NL-1:0] a_we = '0, b_we = '0;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic [DW-1:0] a_wdata = '0, b_wdata = '0;
    logic [DW-1:0] a_rd, b_rd, ka_rd, kb_rd;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // A shows old, B shows new with output pipeline
    twin_port_ram #(
        .LANES(NL), .DEPTH(DEP),
        .MODE_A(WR_SHOW_OLD), .MODE_B(WR_SHOW_NEW),
        .PIPE_A(1'b0), .PIPE_B(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rd),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rd)
    );

    // A keeps output, B shows old, no pipelines; same stimulus
    twin_port_ram #(
        .LANES(NL), .DEPTH(DEP),
        .MODE_A(WR_KEEP_OUT), .MODE_B(WR_SHOW_OLD),
        .PIPE_A(1'b0), .PIPE_B(1'b0)
    ) dut_keep_i (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(ka_rd),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(kb_rd)
    );

    function automatic logic [DW-1:0] mrg(logic [DW-1:0] old_w, logic [DW-1:0] new_w,
                                          logic [NL-1:0] we);
        logic [DW-1:0] r = old_w;
        for (int l = 0; l < NL; l++) begin
            if (we[l]) r[l*9 +: 9] = new_w[l*9 +: 9];
        end
        return r;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One edge with the given inputs; returns at the following falling edge
    task automatic step(logic ae, logic [NL-1:0] aw, logic [AW-1:0] aa, logic [DW-1:0] ad,
                        logic be, logic [NL-1:0] bw, logic [AW-1:0] ba, logic [DW-1:0] bd);
        a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
        b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
        @(posedge clk);
        @(negedge clk);
        a_en = 1'b0; a_we = '0; b_en = 1'b0; b_we = '0;
    endtask

    task automatic idle();
        step(1'b0, '0, '0, '0, 1'b0, '0, '0, '0);
    endtask

    localparam logic [DW-1:0] D1 = 36'h9_A1B2_C3D4;
    localparam logic [DW-1:0] D2 = 36'h4_0F1E_2D3C;
    localparam logic [DW-1:0] D3 = 36'hF_FFFF_FFFF;
    localparam logic [DW-1:0] D4 = 36'h1_2345_6789;
    localparam logic [DW-1:0] D5 = 36'h0_0000_0000;
    localparam logic [DW-1:0] D6 = 36'h8_5555_AAAA;
    localparam logic [DW-1:0] D7 = 36'h7_AAAA_5555;
    localparam logic [DW-1:0] D8 = 36'hC_1357_9BDF;
    localparam logic [DW-1:0] D9 = 36'h3_2468_ACE0;

    logic [DW-1:0] m3;

    task automatic t_reset();
        chk("R10 reset a_rd", a_rd, '0);
        chk("R10 reset b_rd", b_rd, '0);
        chk("R10 reset ka_rd", ka_rd, '0);
        chk("R10 reset kb_rd", kb_rd, '0);
    endtask

    task automatic t_write_first();
        step(1'b0, '0, '0, '0, 1'b1, 4'hF, 6'd3, D1);
        chk("R9 pipe still old", b_rd, '0);
        chk("R7 idle port A holds", a_rd, '0);
        idle();
        chk("R4 write-first full word", b_rd, D1);
        m3 = D1;
    endtask

    task automatic t_read_first_keep();
        step(1'b1, 4'h0, 6'd3, '0, 1'b0, '0, '0, '0);
        chk("R2 read A addr3", a_rd, D1);
        chk("R1 B-written word read on A", ka_rd, D1);
        step(1'b1, 4'hF, 6'd3, D2, 1'b0, '0, '0, '0);
        chk("R3 read-first shows old", a_rd, D1);
        chk("R5 keep-output unchanged", ka_rd, D1);
        m3 = D2;
        step(1'b1, 4'h0, 6'd3, '0, 1'b0, '0, '0, '0);
        chk("R2 read back after write", a_rd, D2);
        chk("R5 keep port reads normally", ka_rd, D2);
    endtask

    task automatic t_lanes();
        step(1'b1, 4'b0101, 6'd3, D3, 1'b0, '0, '0, '0);
        m3 = mrg(m3, D3, 4'b0101);
        step(1'b1, 4'h0, 6'd3, '0, 1'b0, '0, '0, '0);
        chk("R6 lanes 0,2 written with parity", a_rd, m3);
        step(1'b0, '0, '0, '0, 1'b1, 4'b1010, 6'd3, D4);
        m3 = mrg(m3, D4, 4'b1010);
        idle();
        chk("R4 R6 write-first merged lanes", b_rd, m3);
    endtask

    task automatic t_enable_low();
        step(1'b1, 4'h0, 6'd3, '0, 1'b0, '0, '0, '0);
        chk("R2 read before disabled write", a_rd, m3);
        step(1'b0, 4'hF, 6'd3, D5, 1'b0, '0, '0, '0);
        chk("R7 read data holds with en low", a_rd, m3);
        step(1'b1, 4'h0, 6'd3, '0, 1'b0, '0, '0, '0);
        chk("R7 array untouched with en low", a_rd, m3);
    endtask

    task automatic t_cross();
        step(1'b1, 4'hF, 6'd7, D6, 1'b0, '0, '0, '0);
        step(1'b1, 4'hF, 6'd7, D7, 1'b1, 4'h0, 6'd7, '0);
        chk("R8 other-port read sees old word", kb_rd, D6);
        idle();
        chk("R8 R9 piped other-port read old", b_rd, D6);
        step(1'b0, '0, '0, '0, 1'b1, 4'h0, 6'd7, '0);
        idle();
        chk("R8 later read sees new word", b_rd, D7);
    endtask

    task automatic t_dual_write();
        step(1'b1, 4'hF, 6'd10, D8, 1'b1, 4'hF, 6'd20, D9);
        step(1'b1, 4'h0, 6'd20, '0, 1'b1, 4'h0, 6'd10, '0);
        chk("R1 A reads B's write", a_rd, D9);
        chk("R1 B reads A's write", kb_rd, D8);
        chk("R9 pipe shows previous register", b_rd, D9);
        idle();
        chk("R1 R9 piped B reads A's write", b_rd, D8);
    endtask

    task automatic t_hold();
        for (int i = 0; i < 5; i++) idle();
        chk("R12 A holds across idle", a_rd, D9);
        chk("R12 B holds across idle", b_rd, D8);
        chk("R12 keep-dut B holds", kb_rd, D8);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_first();
        t_read_first_keep();
        t_lanes();
        t_enable_low();
        t_cross();
        t_dual_write();
        t_hold();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule